// File: doc/BRIEF.md
# CPU Exception Entry Sequencer

This block decides when a processor core leaves normal execution to handle an exception, and then runs the entry sequence for it. There are two kinds of entry. A reset entry is started by the rising edge of the reset pin. A non-reset entry is started by an address error, an interrupt, a trap instruction or an illegal opcode. The block keeps the cause it accepted, saves machine state to the stack, and reads the handler address from a vector table. At the end it issues a single commit cycle that hands new values for PC, stack pointer (R15), vector base (VBR) and the status-register interrupt mask back to the core.

Stack pushes and vector reads travel over a simple valid/ready memory port. The block raises `mem_valid` together with `mem_addr`, `mem_write` and `mem_wdata`. It holds all four unchanged until the cycle in which `mem_ready` is high, and that cycle completes the transfer. For a read, the memory presents `mem_rdata` in that same cycle. Back-pressure from the memory only stretches the sequence. While `exc_busy` is high the core is expected to stall, and any new cause raised in that time is dropped.

Top module: `exc_entry_seq`

## Requirements
- R1: When `res_n` rises, a high `nmi` gives a power-on entry (cause code 1) that reads PC from 0x0 and then SP from 0x4. A low `nmi` gives a manual entry (cause code 2) that reads PC from 0x8 and then SP from 0xC.
- R2: The reset commit loads PC and SP with the two words read, loads VBR with 0 and loads the mask with 4'b1111. While `res_n` is low, `exc_busy` is 1 and no memory request is made.
- R3: A non-reset entry first writes `cur_sr` to R15-4 and then writes `ret_pc` to R15-8. It commits SP as R15-8.
- R4: The handler PC is the word read at VBR + 4 × vector. The vector is 9 for an address error (code 3), `irq_vec` for an interrupt (code 4), `trap_imm` for a trap (code 5), 4 for a general illegal opcode (code 6) and 6 for a slot illegal opcode (code 7).
- R5: An address error or an interrupt is taken only in a cycle where `insn_done` is high. A trap or an illegal opcode is taken in the cycle its strobe is seen.
- R6: An undefined opcode outside a delay slot is general illegal. An undefined opcode in a delay slot, or a PC-writing instruction in a delay slot, is slot illegal. A PC-writing instruction outside a delay slot starts nothing.
- R7: An interrupt is accepted only if `irq_level` is greater than the current mask `cur_sr[7:4]`. Its commit loads the mask with `irq_level`. Other non-reset entries leave `mask_load` low.
- R8: When several causes can be taken in the same cycle, the order is address error, then interrupt, then instruction exceptions. Reset overrides everything.
- R9: Once `mem_valid` is high it stays high, with address, direction and write data unchanged, until `mem_ready` is seen.
- R10: With `mem_ready` held high, the commit pulse comes 4 cycles after the triggering edge for a non-reset entry, and 3 cycles after the release edge for a reset. The load strobes last one cycle, `exc_busy` falls right after them, and causes raised while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| res_n | input | 1 | Reset pin, active low; its rising edge starts reset entry |
| nmi | input | 1 | NMI pin level, sampled at reset release |
| cur_sr | input | 32 | Current status register, mask in bits 7:4 |
| cur_r15 | input | 32 | Current stack pointer |
| cur_vbr | input | 32 | Current vector base |
| ret_pc | input | 32 | PC value to save on the stack |
| insn_done | input | 1 | Executing instruction completes this cycle |
| addr_err | input | 1 | Address error detected at decode |
| irq_req | input | 1 | Interrupt pending |
| irq_level | input | 4 | Priority of the pending interrupt |
| irq_vec | input | 8 | Vector number of the pending interrupt |
| trap_exec | input | 1 | Trap instruction executes |
| trap_imm | input | 8 | Trap vector number |
| undef_dec | input | 1 | Undefined opcode decoded |
| pc_write_dec | input | 1 | PC-writing instruction decoded |
| in_delay_slot | input | 1 | Decoded instruction sits in a delay slot |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request (read data valid) |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ready` |
| exc_busy | output | 1 | Entry sequence in progress |
| exc_cause | output | 3 | Cause code of the entry in progress (0 when idle) |
| pc_load | output | 1 | Commit strobe for PC |
| pc_value | output | 32 | New PC |
| sp_load | output | 1 | Commit strobe for R15 |
| sp_value | output | 32 | New R15 |
| vbr_load | output | 1 | Commit strobe for VBR |
| vbr_value | output | 32 | New VBR |
| mask_load | output | 1 | Commit strobe for the SR mask |
| mask_value | output | 4 | New SR mask |

## Verification
A cause sampled at a rising edge moves the sequencer into its first push state on that edge. With an always-ready memory, the commit strobes then appear after the fourth edge counted from the trigger. A reset entry needs one edge fewer, because it makes two reads and no pushes. The bench changes inputs only on falling edges. After each rising edge it looks at the outputs on the next falling edge and counts edges until `pc_load` shows, so the latency itself is one of the checks. In the tests where it toggles `mem_ready`, it checks only the committed values and the logged bus writes, not the latency.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int VEC_W = 8;
  localparam int LVL_W = 4;

  typedef enum logic [2:0] {
    CAUSE_NONE = 3'd0,
    CAUSE_POR  = 3'd1,
    CAUSE_MAN  = 3'd2,
    CAUSE_AERR = 3'd3,
    CAUSE_IRQ  = 3'd4,
    CAUSE_TRAP = 3'd5,
    CAUSE_GILL = 3'd6,
    CAUSE_SILL = 3'd7
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RHOLD,
    ST_RPC,
    ST_RSP,
    ST_PSR,
    ST_PPC,
    ST_RVEC,
    ST_COMMIT
  } step_e;

  typedef struct packed {
    cause_e           cause;
    logic [VEC_W-1:0] vec;
    logic [LVL_W-1:0] lvl;
  } pick_t;
endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb
  import exc_entry_pkg::*;
#(
  parameter int VEC_AERR = 9,
  parameter int VEC_GILL = 4,
  parameter int VEC_SILL = 6
) (
  input  logic             insn_done,
  input  logic             addr_err,
  input  logic             irq_req,
  input  logic [LVL_W-1:0] irq_level,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [LVL_W-1:0] cur_mask,
  input  logic             trap_exec,
  input  logic [VEC_W-1:0] trap_imm,
  input  logic             undef_dec,
  input  logic             pc_write_dec,
  input  logic             in_delay_slot,
  output pick_t            pick
);
  logic irq_ok;
  logic slot_bad;

  assign irq_ok   = irq_req && (irq_level > cur_mask);
  assign slot_bad = in_delay_slot && (undef_dec || pc_write_dec);

  always_comb begin
    pick = '{cause: CAUSE_NONE, vec: '0, lvl: '0};
    if (insn_done && addr_err) begin
      pick.cause = CAUSE_AERR;
      pick.vec   = VEC_W'(VEC_AERR);
    end else if (insn_done && irq_ok) begin
      pick.cause = CAUSE_IRQ;
      pick.vec   = irq_vec;
      pick.lvl   = irq_level;
    end else if (slot_bad) begin
      pick.cause = CAUSE_SILL;
      pick.vec   = VEC_W'(VEC_SILL);
    end else if (undef_dec && !in_delay_slot) begin
      pick.cause = CAUSE_GILL;
      pick.vec   = VEC_W'(VEC_GILL);
    end else if (trap_exec) begin
      pick.cause = CAUSE_TRAP;
      pick.vec   = trap_imm;
    end
  end
endmodule

// File: rtl/exc_addr_gen.sv
module exc_addr_gen
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RST_BASE = '0
) (
  input  step_e            step,
  input  logic             por,
  input  logic [XLEN-1:0]  r15,
  input  logic [XLEN-1:0]  vbr,
  input  logic [XLEN-1:0]  sr,
  input  logic [XLEN-1:0]  pc,
  input  logic [VEC_W-1:0] vec,
  output logic             req,
  output logic             wr,
  output logic [XLEN-1:0]  addr,
  output logic [XLEN-1:0]  wdata
);
  localparam int WORD = 4;
  localparam int PAD  = XLEN - VEC_W - 2;

  logic [XLEN-1:0] rst_pair;
  logic [XLEN-1:0] vec_off;

  assign rst_pair = RST_BASE + (por ? XLEN'(0) : XLEN'(2 * WORD));
  assign vec_off  = {{PAD{1'b0}}, vec, 2'b00};

  always_comb begin
    req   = 1'b0;
    wr    = 1'b0;
    addr  = '0;
    wdata = '0;
    unique case (step)
      ST_RPC: begin
        req  = 1'b1;
        addr = rst_pair;
      end
      ST_RSP: begin
        req  = 1'b1;
        addr = rst_pair + XLEN'(WORD);
      end
      ST_PSR: begin
        req   = 1'b1;
        wr    = 1'b1;
        addr  = r15 - XLEN'(WORD);
        wdata = sr;
      end
      ST_PPC: begin
        req   = 1'b1;
        wr    = 1'b1;
        addr  = r15 - XLEN'(2 * WORD);
        wdata = pc;
      end
      ST_RVEC: begin
        req  = 1'b1;
        addr = vbr + vec_off;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_seq_ctrl.sv
module exc_seq_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic             clk,
  input  logic             res_n,
  input  logic             nmi,
  input  pick_t            pick,
  input  logic [XLEN-1:0]  cur_r15,
  input  logic [XLEN-1:0]  cur_vbr,
  input  logic [XLEN-1:0]  cur_sr,
  input  logic [XLEN-1:0]  ret_pc,
  input  logic             mem_ready,
  input  logic [XLEN-1:0]  mem_rdata,
  output step_e            step,
  output cause_e           cause,
  output logic [XLEN-1:0]  r15_q,
  output logic [XLEN-1:0]  vbr_q,
  output logic [XLEN-1:0]  sr_q,
  output logic [XLEN-1:0]  pc_q,
  output logic [VEC_W-1:0] vec_q,
  output logic [LVL_W-1:0] lvl_q,
  output logic [XLEN-1:0]  pc_f,
  output logic [XLEN-1:0]  sp_f
);
  always_ff @(posedge clk) begin
    if (!res_n) begin
      step  <= ST_RHOLD;
      cause <= CAUSE_NONE;
    end else begin
      unique case (step)
        ST_RHOLD: begin
          cause <= nmi ? CAUSE_POR : CAUSE_MAN;
          step  <= ST_RPC;
        end
        ST_RPC: if (mem_ready) begin
          pc_f <= mem_rdata;
          step <= ST_RSP;
        end
        ST_RSP: if (mem_ready) begin
          sp_f <= mem_rdata;
          step <= ST_COMMIT;
        end
        ST_IDLE: if (pick.cause != CAUSE_NONE) begin
          cause <= pick.cause;
          vec_q <= pick.vec;
          lvl_q <= pick.lvl;
          r15_q <= cur_r15;
          vbr_q <= cur_vbr;
          sr_q  <= cur_sr;
          pc_q  <= ret_pc;
          step  <= ST_PSR;
        end
        ST_PSR: if (mem_ready) step <= ST_PPC;
        ST_PPC: if (mem_ready) step <= ST_RVEC;
        ST_RVEC: if (mem_ready) begin
          pc_f <= mem_rdata;
          sp_f <= r15_q - XLEN'(8);
          step <= ST_COMMIT;
        end
        ST_COMMIT: begin
          cause <= CAUSE_NONE;
          step  <= ST_IDLE;
        end
        default: step <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int MASK_LSB = 4,
  parameter int VEC_AERR = 9,
  parameter int VEC_GILL = 4,
  parameter int VEC_SILL = 6
) (
  input  logic             clk,
  input  logic             res_n,
  input  logic             nmi,
  input  logic [XLEN-1:0]  cur_sr,
  input  logic [XLEN-1:0]  cur_r15,
  input  logic [XLEN-1:0]  cur_vbr,
  input  logic [XLEN-1:0]  ret_pc,
  input  logic             insn_done,
  input  logic             addr_err,
  input  logic             irq_req,
  input  logic [3:0]       irq_level,
  input  logic [7:0]       irq_vec,
  input  logic             trap_exec,
  input  logic [7:0]       trap_imm,
  input  logic             undef_dec,
  input  logic             pc_write_dec,
  input  logic             in_delay_slot,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_write,
  output logic [XLEN-1:0]  mem_addr,
  output logic [XLEN-1:0]  mem_wdata,
  input  logic [XLEN-1:0]  mem_rdata,
  output logic             exc_busy,
  output logic [2:0]       exc_cause,
  output logic             pc_load,
  output logic [XLEN-1:0]  pc_value,
  output logic             sp_load,
  output logic [XLEN-1:0]  sp_value,
  output logic             vbr_load,
  output logic [XLEN-1:0]  vbr_value,
  output logic             mask_load,
  output logic [3:0]       mask_value
);
  pick_t            pick;
  step_e            step;
  cause_e           cause;
  logic [XLEN-1:0]  r15_q, vbr_q, sr_q, pc_q, pc_f, sp_f;
  logic [VEC_W-1:0] vec_q;
  logic [LVL_W-1:0] lvl_q;
  logic             is_rst;
  logic             commit;

  exc_cause_arb #(
    .VEC_AERR(VEC_AERR), .VEC_GILL(VEC_GILL), .VEC_SILL(VEC_SILL)
  ) u_arb (
    .insn_done    (insn_done),
    .addr_err     (addr_err),
    .irq_req      (irq_req),
    .irq_level    (irq_level),
    .irq_vec      (irq_vec),
    .cur_mask     (cur_sr[MASK_LSB +: LVL_W]),
    .trap_exec    (trap_exec),
    .trap_imm     (trap_imm),
    .undef_dec    (undef_dec),
    .pc_write_dec (pc_write_dec),
    .in_delay_slot(in_delay_slot),
    .pick         (pick)
  );

  exc_seq_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk      (clk),
    .res_n    (res_n),
    .nmi      (nmi),
    .pick     (pick),
    .cur_r15  (cur_r15),
    .cur_vbr  (cur_vbr),
    .cur_sr   (cur_sr),
    .ret_pc   (ret_pc),
    .mem_ready(mem_ready),
    .mem_rdata(mem_rdata),
    .step     (step),
    .cause    (cause),
    .r15_q    (r15_q),
    .vbr_q    (vbr_q),
    .sr_q     (sr_q),
    .pc_q     (pc_q),
    .vec_q    (vec_q),
    .lvl_q    (lvl_q),
    .pc_f     (pc_f),
    .sp_f     (sp_f)
  );

  exc_addr_gen #(.XLEN(XLEN)) u_agen (
    .step (step),
    .por  (cause == CAUSE_POR),
    .r15  (r15_q),
    .vbr  (vbr_q),
    .sr   (sr_q),
    .pc   (pc_q),
    .vec  (vec_q),
    .req  (mem_valid),
    .wr   (mem_write),
    .addr (mem_addr),
    .wdata(mem_wdata)
  );

  assign is_rst     = (cause == CAUSE_POR) || (cause == CAUSE_MAN);
  assign commit     = (step == ST_COMMIT);
  assign exc_busy   = (step != ST_IDLE);
  assign exc_cause  = cause;
  assign pc_load    = commit;
  assign pc_value   = pc_f;
  assign sp_load    = commit;
  assign sp_value   = sp_f;
  assign vbr_load   = commit && is_rst;
  assign vbr_value  = '0;
  assign mask_load  = commit && (is_rst || cause == CAUSE_IRQ);
  assign mask_value = is_rst ? 4'hF : lvl_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN     = 32,
  parameter int MASK_LSB = 4
) (
  input logic            clk,
  input logic            res_n,
  input logic            insn_done,
  input logic            addr_err,
  input logic            irq_req,
  input logic [3:0]      irq_level,
  input logic [XLEN-1:0] cur_sr,
  input logic            mem_valid,
  input logic            mem_ready,
  input logic            mem_write,
  input logic [XLEN-1:0] mem_addr,
  input logic [XLEN-1:0] mem_wdata,
  input logic            exc_busy,
  input logic [2:0]      exc_cause,
  input logic            pc_load,
  input logic            sp_load,
  input logic            vbr_load,
  input logic [XLEN-1:0] vbr_value,
  input logic            mask_load,
  input logic [3:0]      mask_value
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!res_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr)
      && $stable(mem_write) && $stable(mem_wdata));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!res_n)
    pc_load |=> !pc_load && !exc_busy);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!res_n)
    !exc_busy |-> !mem_valid && !pc_load && !sp_load);

  assert_rst_commit_R2: assert property (@(posedge clk) disable iff (!res_n)
    vbr_load |-> vbr_value == '0 && mask_load && mask_value == 4'hF
      && pc_load && sp_load);

  assert_mask_src_R7: assert property (@(posedge clk) disable iff (!res_n)
    mask_load |-> (exc_cause == 3'd1 || exc_cause == 3'd2 || exc_cause == 3'd4));

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!res_n)
    $rose(exc_busy) && exc_cause == 3'd4 |->
      $past(irq_req && insn_done && irq_level > cur_sr[MASK_LSB +: 4]));

  assert_aerr_gate_R5: assert property (@(posedge clk) disable iff (!res_n)
    $rose(exc_busy) && exc_cause == 3'd3 |-> $past(insn_done && addr_err));
endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .MASK_LSB(MASK_LSB)) u_chk (.*);

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  logic        clk = 1'b0;
  logic        res_n = 1'b0;
  logic        nmi = 1'b1;
  logic [31:0] cur_sr = '0, cur_r15 = '0, cur_vbr = '0, ret_pc = '0;
  logic        insn_done = 0, addr_err = 0, irq_req = 0;
  logic [3:0]  irq_level = '0;
  logic [7:0]  irq_vec = '0, trap_imm = '0;
  logic        trap_exec = 0, undef_dec = 0, pc_write_dec = 0, in_delay_slot = 0;
  logic        mem_valid, mem_ready, mem_write;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        exc_busy, pc_load, sp_load, vbr_load, mask_load;
  logic [2:0]  exc_cause;
  logic [31:0] pc_value, sp_value, vbr_value;
  logic [3:0]  mask_value;

  logic        bp_en = 1'b0;
  logic        bp_ph = 1'b0;
  int          n_chk = 0;
  int          n_fail = 0;
  int          wn = 0;
  logic [31:0] log_a [0:255];
  logic [31:0] log_d [0:255];

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rd_of(input logic [31:0] a);
    return a ^ 32'h3C5A_0F00;
  endfunction

  assign mem_ready = !bp_en || bp_ph;
  assign mem_rdata = rd_of(mem_addr);

  always @(posedge clk) begin
    bp_ph <= ~bp_ph;
    if (res_n && mem_valid && mem_ready && mem_write) begin
      log_a[wn[7:0]] <= mem_addr;
      log_d[wn[7:0]] <= mem_wdata;
      wn <= wn + 1;
    end
  end

  exc_entry_seq dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clr_trig();
    insn_done = 0; addr_err = 0; irq_req = 0; trap_exec = 0;
    undef_dec = 0; pc_write_dec = 0; in_delay_slot = 0;
  endtask

  // waits (from a falling edge with stimulus applied) for the commit pulse
  task automatic wait_commit(output int lat);
    lat = 0;
    for (int i = 1; i <= 60; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 1) clr_trig();
      if (pc_load) begin lat = i; break; end
    end
  endtask

  task automatic do_reset(input logic nmi_lvl, input logic [31:0] base, input logic [2:0] code);
    int lat;
    @(negedge clk);
    res_n = 0;
    repeat (3) @(negedge clk);
    chk("R2 busy in reset", {31'd0, exc_busy}, 32'd1);
    chk("R2 no request in reset", {31'd0, mem_valid}, 32'd0);
    nmi = nmi_lvl;
    res_n = 1;
    wait_commit(lat);
    chk("R10 reset latency", lat, 3);
    chk("R1 reset cause", {29'd0, exc_cause}, {29'd0, code});
    chk("R1 PC vector", pc_value, rd_of(base));
    chk("R1 SP vector", sp_value, rd_of(base + 4));
    chk("R2 vbr load", {31'd0, vbr_load}, 32'd1);
    chk("R2 vbr value", vbr_value, 32'd0);
    chk("R2 mask", {27'd0, mask_load, mask_value}, {27'd0, 1'b1, 4'hF});
    @(negedge clk);
    chk("R10 busy falls", {31'd0, exc_busy}, 32'd0);
  endtask

  // common check of a non-reset entry already triggered at this falling edge
  task automatic entry_check(input string tag, input logic [2:0] code, input logic [7:0] vec,
                             input logic mlod, input logic [3:0] mval, input bit chk_lat);
    int lat; int w0;
    logic [31:0] r15, vbr, sr, pc;
    r15 = cur_r15; vbr = cur_vbr; sr = cur_sr; pc = ret_pc; w0 = wn;
    wait_commit(lat);
    if (chk_lat) chk({tag, " R10 latency"}, lat, 4);
    chk({tag, " R4 cause"}, {29'd0, exc_cause}, {29'd0, code});
    chk({tag, " R4 handler pc"}, pc_value, rd_of(vbr + {22'd0, vec, 2'b00}));
    chk({tag, " R3 sp"}, sp_value, r15 - 8);
    chk({tag, " R3 push1 addr"}, log_a[w0[7:0]], r15 - 4);
    chk({tag, " R3 push1 data"}, log_d[w0[7:0]], sr);
    chk({tag, " R3 push2 addr"}, log_a[w0[7:0] + 8'd1], r15 - 8);
    chk({tag, " R3 push2 data"}, log_d[w0[7:0] + 8'd1], pc);
    chk({tag, " R3 write count"}, wn - w0, 2);
    chk({tag, " R7 mask load"}, {31'd0, mask_load}, {31'd0, mlod});
    if (mlod) chk({tag, " R7 mask value"}, {28'd0, mask_value}, {28'd0, mval});
    chk({tag, " R2 no vbr load"}, {31'd0, vbr_load}, 32'd0);
    @(negedge clk);
  endtask

  task automatic set_ctx(input logic [31:0] r15, input logic [31:0] vbr,
                         input logic [3:0] msk, input logic [31:0] pc);
    cur_r15 = r15; cur_vbr = vbr; cur_sr = 32'h0000_0001 | {24'd0, msk, 4'd0}; ret_pc = pc;
  endtask

  task automatic t_trap();
    @(negedge clk);
    set_ctx(32'h0000_0800, 32'h0000_1000, 4'd2, 32'h0000_0446);
    trap_exec = 1; trap_imm = 8'h21;
    entry_check("trap R5", 3'd5, 8'h21, 1'b0, 4'd0, 1);
  endtask

  task automatic t_illegal();
    @(negedge clk);
    set_ctx(32'h0000_2000, 32'h0000_4000, 4'd0, 32'h100);
    undef_dec = 1;
    entry_check("gen R6", 3'd6, 8'd4, 1'b0, 4'd0, 1);
    set_ctx(32'h0000_2100, 32'h0000_4000, 4'd0, 32'h200);
    undef_dec = 1; in_delay_slot = 1;
    entry_check("slot undef R6", 3'd7, 8'd6, 1'b0, 4'd0, 1);
    set_ctx(32'h0000_2200, 32'h0000_4400, 4'd0, 32'h300);
    pc_write_dec = 1; in_delay_slot = 1;
    entry_check("slot pcw R6", 3'd7, 8'd6, 1'b0, 4'd0, 1);
    pc_write_dec = 1; in_delay_slot = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R6 pc-write outside slot ignored", {30'd0, exc_busy, mem_valid}, 32'd0);
    end
    clr_trig();
  endtask

  task automatic t_addr_err();
    @(negedge clk);
    set_ctx(32'h0000_3000, 32'h0000_0200, 4'd6, 32'h0000_0AAA);
    addr_err = 1;
    repeat (3) begin
      @(negedge clk);
      chk("R5 address error waits", {31'd0, exc_busy}, 32'd0);
    end
    insn_done = 1;
    entry_check("aerr R5", 3'd3, 8'd9, 1'b0, 4'd0, 1);
  endtask

  task automatic t_irq();
    @(negedge clk);
    set_ctx(32'h0000_5000, 32'h0000_0600, 4'd3, 32'h0000_0BB0);
    irq_req = 1; irq_level = 4'd3; irq_vec = 8'h40; insn_done = 1;
    repeat (3) begin
      @(negedge clk);
      chk("R7 level equal to mask refused", {31'd0, exc_busy}, 32'd0);
    end
    irq_level = 4'd5;
    entry_check("irq R7", 3'd4, 8'h40, 1'b1, 4'd5, 1);
  endtask

  task automatic t_priority();
    @(negedge clk);
    set_ctx(32'h0000_6000, 32'h0000_0000, 4'd1, 32'h0000_0C00);
    addr_err = 1; irq_req = 1; irq_level = 4'd9; irq_vec = 8'h50;
    trap_exec = 1; trap_imm = 8'h22; insn_done = 1;
    entry_check("prio aerr R8", 3'd3, 8'd9, 1'b0, 4'd0, 1);
    irq_req = 1; irq_level = 4'd9; irq_vec = 8'h50; undef_dec = 1; insn_done = 1;
    entry_check("prio irq R8", 3'd4, 8'h50, 1'b1, 4'd9, 1);
  endtask

  task automatic t_busy_ignore();
    int lat;
    @(negedge clk);
    set_ctx(32'h0000_7000, 32'h0000_0100, 4'd0, 32'h0000_0D00);
    trap_exec = 1; trap_imm = 8'h30;
    @(posedge clk); @(negedge clk);
    trap_exec = 0; undef_dec = 1;
    @(posedge clk); @(negedge clk);
    undef_dec = 0;
    for (int i = 0; i < 10 && !pc_load; i++) @(negedge clk);
    chk("R10 cause kept while busy", {29'd0, exc_cause}, 32'd5);
    chk("R10 handler of first cause", pc_value, rd_of(32'h100 + 32'h30 * 4));
    repeat (2) begin
      @(negedge clk);
      chk("R10 dropped cause not taken", {31'd0, exc_busy}, 32'd0);
    end
  endtask

  task automatic t_backpressure();
    bp_en = 1;
    @(negedge clk);
    set_ctx(32'h0000_8000, 32'h0000_0300, 4'd0, 32'h0000_0E00);
    trap_exec = 1; trap_imm = 8'h11;
    entry_check("bp R9", 3'd5, 8'h11, 1'b0, 4'd0, 0);
    bp_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b1, 32'h0, 3'd1);
    do_reset(1'b0, 32'h8, 3'd2);
    t_trap();
    t_illegal();
    t_addr_err();
    t_irq();
    t_priority();
    t_busy_ignore();
    t_backpressure();
    do_reset(1'b1, 32'h0, 3'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule